// File: doc/BRIEF.md
# Free-Running Timer Counter with Access-Triggered Flag Clearing

This block is a free-running up-counter with a small register file on a byte/word bus. A control register holds an enable bit, two halt-condition bits (halt during low-power wait, halt during debug) and a fast-clear bit. An overflow flag and a bank of channel flags latch events. They can be cleared in two ways. The normal way is a write-one-to-clear to the flag register. In fast-clear mode, the ordinary data accesses that software makes anyway also clear the flags, so no separate clear write is needed.

A three-state run machine decides whether the timer is running. The state is OFF when the enable bit is 0. It is RUN when the timer is enabled and no halt condition holds. It is HELD when the timer is enabled but stopped by wait or debug mode. The transitions are named by their conditions: OFF->RUN on enable with no halt, OFF->HELD on enable with a halt, RUN->HELD when a halt starts, HELD->RUN when the halt ends, and RUN->OFF or HELD->OFF when the enable bit is cleared.

In RUN, the counter advances on each prescaler tick, and a free-running divider produces a one-cycle pulse for an external pulse accumulator. Software can write the counter only while the special-mode input is high.

Top module: `tmr_fastclr_timer`

## Requirements
- R1: After reset the control register, counter, overflow flag and channel flags are all 0, and the run machine is in OFF.
- R2: The run state is updated one cycle after its conditions change. The counter increments by one at each clock edge where the state is RUN and `presc_tick` is 1. In OFF or HELD the counter holds its value.
- R3: With control bit 1 (halt-in-wait) set and `wait_mode` high, the state is HELD. With bit 1 clear, `wait_mode` has no effect.
- R4: With control bit 2 (halt-in-debug) set and `dbg_mode` high, the state is HELD. With bit 2 clear, `dbg_mode` has no effect.
- R5: Counter writes take effect only while `special_mode` is 1. They are ignored otherwise. A word write to address 0x00 loads all 16 bits. A byte write loads `bus_wdata[7:0]` into the high byte at address 0x00 or into the low byte at address 0x01. A write takes priority over an increment.
- R6: An increment from 0xFFFF to 0x0000 sets the overflow flag, which is bit 0 at address 0x03.
- R7: Writing a 1 to bit 0 of address 0x03 clears the overflow flag. Writing a 1 to bit i of address 0x04 clears channel flag i. Writing 0 bits leaves the flags unchanged. A set event wins over a clear in the same cycle.
- R8: With control bit 3 (fast-clear) set, any read or write of address 0x00 or 0x01 clears the overflow flag.
- R9: With fast-clear set, accesses to channel i at address 0x10+i clear channel flag i in two cases: a read when `ch_is_capture[i]`=1, or a write when `ch_is_capture[i]`=0. An access in the other direction leaves the flag set.
- R10: With fast-clear clear, counter and channel accesses leave all flags unchanged.
- R11: `pa_tick` pulses for one cycle every 64 RUN cycles (divider width 6). Outside RUN it stays low and the divider holds its value.
- R12: A word read at address 0x00 returns the full counter in one access. Byte reads at 0x00 and 0x01 return the high and low bytes on `bus_rdata[7:0]`. Address 0x02 reads back the control bits in [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| special_mode | input | 1 | Enables counter writes |
| wait_mode | input | 1 | Device in low-power wait |
| dbg_mode | input | 1 | Device in debug/background mode |
| presc_tick | input | 1 | Prescaler tick, counter advance strobe |
| ch_event | input | 8 | Per-channel flag set pulses |
| ch_is_capture | input | 8 | Per-channel: 1 = input capture, 0 = output compare |
| ovf_flag | output | 1 | Overflow flag |
| ch_flag | output | 8 | Channel flags |
| pa_tick | output | 1 | Divided pulse for the pulse accumulator |

## Verification
The assertions assume a bus access lasts exactly one cycle, and that `ch_event` and `presc_tick` are plain synchronous levels, with no other timing convention attached to them. The stimulus drives every input at the falling edge, and each bus operation holds `bus_en` high for a single cycle. It keeps `presc_tick` low while the control or mode inputs change and waits two cycles before ticking. As a result, the run state has settled before any increment that the bench predicts arithmetically.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_RUN  = 2'b01,
        ST_HELD = 2'b10
    } tmr_state_e;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI  = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO  = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 5'h02;
    localparam logic [ADDR_W-1:0] ADR_OVF     = 5'h03;
    localparam logic [ADDR_W-1:0] ADR_CHF     = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_CH_BASE = 5'h10;

    localparam int CB_EN    = 0;
    localparam int CB_SWAIT = 1;
    localparam int CB_SDBG  = 2;
    localparam int CB_FAST  = 3;
    localparam int CTRL_W   = 4;
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       stop_wait,
    input  logic       stop_dbg,
    input  logic       wait_mode,
    input  logic       dbg_mode,
    output tmr_state_e state_o,
    output logic       run_o
);
    tmr_state_e state_q, state_d;
    logic       halt;

    assign halt = (stop_wait && wait_mode) || (stop_dbg && dbg_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en) state_d = halt ? ST_HELD : ST_RUN;
            ST_RUN:  if (!en) state_d = ST_OFF;
                     else if (halt) state_d = ST_HELD;
            ST_HELD: if (!en) state_d = ST_OFF;
                     else if (!halt) state_d = ST_RUN;
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        state_o = state_q;
        run_o   = (state_q == ST_RUN);
    end

    a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == ST_OFF);
    a_r3_wait_halts: assert property (@(posedge clk) disable iff (!rst_n)
        en && stop_wait && wait_mode |=> state_q == ST_HELD);
    a_r4_dbg_halts: assert property (@(posedge clk) disable iff (!rst_n)
        en && stop_dbg && dbg_mode |=> state_q == ST_HELD);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             pa_tick
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             any_wr, step;

    assign any_wr = wr_hi || wr_lo;
    assign step   = run && tick && !any_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_hi) cnt_q[CNT_W-1:HALF] <= wdata[CNT_W-1:HALF];
            if (wr_lo) cnt_q[HALF-1:0]     <= wdata[HALF-1:0];
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   div_q <= '0;
        else if (run) div_q <= div_q + 1'b1;
    end

    always_comb begin
        cnt     = cnt_q;
        wrap    = step && (&cnt_q);
        pa_tick = run && (&div_q);
    end

    a_r2_counts: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) && !any_wr |=> $stable(cnt_q));
    a_r11_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(div_q));
    a_r11_div_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        pa_tick |=> div_q == '0);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wrap,
    input  logic           ovf_clr,
    input  logic [NCH-1:0] ch_evt,
    input  logic [NCH-1:0] ch_clr,
    output logic           ovf,
    output logic [NCH-1:0] chf
);
    logic           ovf_q;
    logic [NCH-1:0] chf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            chf_q <= '0;
        end else begin
            ovf_q <= wrap || (ovf_q && !ovf_clr);
            chf_q <= ch_evt | (chf_q & ~ch_clr);
        end
    end

    always_comb begin
        ovf = ovf_q;
        chf = chf_q;
    end

    a_r6_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !ovf_clr |=> ovf_q);
    a_r7_ch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ch_clr == '0 |=> (chf_q & $past(chf_q)) == $past(chf_q));
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ch_evt != '0 |=> (chf_q & $past(ch_evt)) == $past(ch_evt));
endmodule

// File: rtl/tmr_fastclr_timer.sv
module tmr_fastclr_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 8,
    parameter int DIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              special_mode,
    input  logic              wait_mode,
    input  logic              dbg_mode,
    input  logic              presc_tick,
    input  logic [NCH-1:0]    ch_event,
    input  logic [NCH-1:0]    ch_is_capture,
    output logic              ovf_flag,
    output logic [NCH-1:0]    ch_flag,
    output logic              pa_tick
);
    localparam int HALF = CNT_W / 2;

    logic [CTRL_W-1:0] ctrl_q;
    tmr_state_e        state;
    logic              run, wrap, ovf, ovf_clr, fast;
    logic              at_hi, at_lo, cnt_acc, wr_hi, wr_lo;
    logic [CNT_W-1:0]  cnt, cnt_wd;
    logic [NCH-1:0]    chf, ch_clr;

    assign fast    = ctrl_q[CB_FAST];
    assign at_hi   = bus_en && (bus_addr == ADR_CNT_HI);
    assign at_lo   = bus_en && (bus_addr == ADR_CNT_LO);
    assign cnt_acc = at_hi || at_lo;
    assign wr_hi   = at_hi && bus_we && special_mode;
    assign wr_lo   = bus_we && special_mode && (at_lo || (at_hi && bus_word));
    assign cnt_wd  = (at_hi && bus_word) ? bus_wdata
                                         : {bus_wdata[HALF-1:0], bus_wdata[HALF-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_en && bus_we && bus_addr == ADR_CTRL)
            ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    assign ovf_clr = (bus_en && bus_we && bus_addr == ADR_OVF && bus_wdata[0])
                   || (fast && cnt_acc);

    for (genvar i = 0; i < NCH; i++) begin : g_chclr
        logic hit;
        assign hit = bus_en && (bus_addr == ADR_CH_BASE + ADDR_W'(i));
        assign ch_clr[i] = (bus_en && bus_we && bus_addr == ADR_CHF && bus_wdata[i])
                         || (fast && hit && (ch_is_capture[i] ? !bus_we : bus_we));
    end

    tmr_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_q[CB_EN]),
        .stop_wait (ctrl_q[CB_SWAIT]),
        .stop_dbg  (ctrl_q[CB_SDBG]),
        .wait_mode (wait_mode),
        .dbg_mode  (dbg_mode),
        .state_o   (state),
        .run_o     (run)
    );

    tmr_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (presc_tick),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wdata   (cnt_wd),
        .cnt     (cnt),
        .wrap    (wrap),
        .pa_tick (pa_tick)
    );

    tmr_flags #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .ovf_clr (ovf_clr),
        .ch_evt  (ch_event),
        .ch_clr  (ch_clr),
        .ovf     (ovf),
        .chf     (chf)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CNT_HI: bus_rdata = bus_word ? cnt : CNT_W'(cnt[CNT_W-1:HALF]);
            ADR_CNT_LO: bus_rdata = CNT_W'(cnt[HALF-1:0]);
            ADR_CTRL:   bus_rdata = CNT_W'(ctrl_q);
            ADR_OVF:    bus_rdata = CNT_W'(ovf);
            ADR_CHF:    bus_rdata = CNT_W'(chf);
            default:    bus_rdata = '0;
        endcase
        ovf_flag = ovf;
        ch_flag  = chf;
    end

    a_r5_no_write_normal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && bus_we && !special_mode && !run |=> $stable(cnt));
    a_r8_fast_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        fast && cnt_acc && !wrap |=> !ovf);
    a_r10_slow_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !fast && cnt_acc |=> ovf);
    a_r1_off_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_EN] == 1'b0 |=> state == ST_OFF);
endmodule

// File: tb/tmr_fastclr_timer_bench.sv
module tmr_fastclr_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 0, bus_we = 0, bus_word = 0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        special_mode = 0, wait_mode = 0, dbg_mode = 0, presc_tick = 0;
    logic [7:0]  ch_event = '0;
    logic [7:0]  ch_is_capture = 8'h0F;
    logic        ovf_flag, pa_tick;
    logic [7:0]  ch_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_fastclr_timer u_tmr_fastclr_timer (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .special_mode(special_mode), .wait_mode(wait_mode), .dbg_mode(dbg_mode),
        .presc_tick(presc_tick), .ch_event(ch_event), .ch_is_capture(ch_is_capture),
        .ovf_flag(ovf_flag), .ch_flag(ch_flag), .pa_tick(pa_tick)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [4:0] a, input logic [15:0] d, input logic w);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_word = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic brd(input logic [4:0] a, input logic w, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_word = w; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic cwr(input logic [15:0] d);
        special_mode = 1;
        bwr(5'h00, d, 1'b1);
        special_mode = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        presc_tick = 1;
        repeat (k) @(negedge clk);
        presc_tick = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] rd;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(1);

        // R1 reset state
        brd(5'h00, 1'b1, rd); chk("R1 count", rd, 16'h0);
        brd(5'h02, 1'b0, rd); chk("R1 ctrl", rd, 16'h0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 chf", ch_flag, 8'h00);

        // R11 divider pulses only while running
        bwr(5'h02, 16'h0001, 1'b0);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pa_tick) pulses++;
        end
        chk("R11 pulses in RUN", pulses, 3);
        bwr(5'h02, 16'h0000, 1'b0);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pa_tick) pulses++;
        end
        chk("R11 pulses when OFF", pulses, 0);

        // R2/R3/R4 sweep over enable, halt bits and mode inputs
        for (int m = 0; m < 32; m++) begin
            logic en, sw, sd, wm, dm, run;
            en = m[0]; sw = m[1]; sd = m[2]; wm = m[3]; dm = m[4];
            run = en && !(sw && wm) && !(sd && dm);
            bwr(5'h02, 16'h0000, 1'b0);
            cwr(16'h0000);
            wait_mode = wm; dbg_mode = dm;
            bwr(5'h02, {13'b0, sd, sw, en}, 1'b0);
            idle(2);
            ticks(5);
            idle(1);
            brd(5'h00, 1'b1, rd);
            if (sw && wm)      chk("R3 halt-in-wait sweep", rd, run ? 16'd5 : 16'd0);
            else if (sd && dm) chk("R4 halt-in-debug sweep", rd, run ? 16'd5 : 16'd0);
            else               chk("R2 run sweep", rd, run ? 16'd5 : 16'd0);
        end
        wait_mode = 0; dbg_mode = 0;
        bwr(5'h02, 16'h0000, 1'b0);

        // R12 control read-back
        bwr(5'h02, 16'h000E, 1'b0);
        brd(5'h02, 1'b0, rd); chk("R12 ctrl readback", rd, 16'h000E);
        bwr(5'h02, 16'h0000, 1'b0);

        // R5 and R12 byte/word counter access
        special_mode = 1;
        bwr(5'h00, 16'h00A5, 1'b0);
        bwr(5'h01, 16'h005A, 1'b0);
        special_mode = 0;
        brd(5'h00, 1'b0, rd); chk("R12 high byte", rd, 16'h00A5);
        brd(5'h01, 1'b0, rd); chk("R12 low byte", rd, 16'h005A);
        brd(5'h00, 1'b1, rd); chk("R5 byte writes, word read", rd, 16'hA55A);
        bwr(5'h00, 16'h1234, 1'b1);
        brd(5'h00, 1'b1, rd); chk("R5 normal-mode write ignored", rd, 16'hA55A);

        // R6 overflow on wrap
        cwr(16'hFFFE);
        bwr(5'h02, 16'h0001, 1'b0);
        idle(2);
        ticks(2);
        bwr(5'h02, 16'h0000, 1'b0);
        chk("R6 ovf set on wrap", ovf_flag, 1);
        brd(5'h00, 1'b1, rd); chk("R6 count wrapped", rd, 16'h0000);
        chk("R10 slow read keeps ovf", ovf_flag, 1);
        bwr(5'h03, 16'h0000, 1'b0);
        chk("R7 zero write keeps ovf", ovf_flag, 1);
        bwr(5'h02, 16'h0008, 1'b0);
        brd(5'h01, 1'b0, rd);
        chk("R8 fast-clear by counter read", ovf_flag, 0);
        bwr(5'h02, 16'h0000, 1'b0);

        // R7 explicit clear of overflow
        cwr(16'hFFFF);
        bwr(5'h02, 16'h0001, 1'b0);
        idle(2);
        ticks(1);
        bwr(5'h02, 16'h0000, 1'b0);
        brd(5'h03, 1'b0, rd); chk("R6 ovf readback", rd, 16'h0001);
        bwr(5'h03, 16'h0001, 1'b0);
        chk("R7 write-one clears ovf", ovf_flag, 0);

        // R8 fast clear by counter write (ignored write still clears)
        cwr(16'hFFFF);
        bwr(5'h02, 16'h0001, 1'b0);
        idle(2);
        ticks(1);
        bwr(5'h02, 16'h0008, 1'b0);
        bwr(5'h01, 16'h0000, 1'b0);
        chk("R8 fast-clear by counter write", ovf_flag, 0);

        // R9 channel fast clearing
        @(negedge clk); ch_event = 8'hFF;
        @(negedge clk); ch_event = 8'h00;
        chk("R7 channel flags set", ch_flag, 8'hFF);
        brd(5'h10, 1'b0, rd);
        bwr(5'h11, 16'h0000, 1'b0);
        bwr(5'h15, 16'h0000, 1'b0);
        brd(5'h16, 1'b0, rd);
        chk("R9 capture read / compare write clear", ch_flag, 8'hDE);

        // R10 no clear with fast-clear off
        bwr(5'h02, 16'h0000, 1'b0);
        brd(5'h12, 1'b0, rd);
        bwr(5'h14, 16'h0000, 1'b0);
        chk("R10 channel accesses keep flags", ch_flag, 8'hDE);

        // R7 write-one-to-clear and set priority
        bwr(5'h04, 16'h0000, 1'b0);
        chk("R7 zero write keeps channel flags", ch_flag, 8'hDE);
        bwr(5'h04, 16'h000C, 1'b0);
        brd(5'h04, 1'b0, rd); chk("R7 write-one clears channels", rd, 16'h00D2);
        @(negedge clk);
        ch_event = 8'h02;
        bus_en = 1; bus_we = 1; bus_word = 0; bus_addr = 5'h04; bus_wdata = 16'h0002;
        @(negedge clk);
        ch_event = 8'h00; bus_en = 0; bus_we = 0;
        chk("R7 set wins over clear", ch_flag, 8'hD2);

        done = 1;
        finish_run();
    end
endmodule